// File: doc/BRIEF.md
# I/O Virtual Address Translator

This block turns I/O virtual addresses that land inside a programmable window into physical addresses. Each virtual page maps to one 64-bit entry in a page directory kept in system memory. On a miss the block reads that entry through a simple request/response port. Recent translations are kept in a small fully associative cache, which software clears by range with a purge command.

Software sets the block up with single-cycle register writes: window base with an enable flag, window mask, page-size code, directory base, and purge. A requester offers a virtual address with a valid/ready handshake. One or more cycles later it gets a one-cycle response carrying either a physical address or a fault flag.

Top module: `iova_translator`

## Requirements
- R1: After reset, translation is disabled, `req_ready` is 1, and both `rsp_valid` and `dir_req_valid` are 0.
- R2: A write to offset 0x300 loads the window base. Bit 0 of the data enables translation and bits above bit 0 give the base address. Writing zero disables the unit, so every request faults. Offset 0x308 holds the window mask, 0x318 the page-size code and 0x320 the directory base.
- R3: An address is in the window when `(va & mask) == (base & mask)`. An address outside the window gets a fault response with a physical address of 0, and no directory read is issued.
- R4: On a miss, one directory read is issued at `dir_base + ((va - base) >> shift) * 8`.
- R5: Page-size codes 0, 1, 2 and 3 select page shifts of 12, 13, 14 and 16 bits. The physical address is the entry's bits [47:shift] joined with the virtual address bits below the shift.
- R6: A page-size code above 3 is invalid, and while it is set every request faults.
- R7: A fetched entry with bit 63 clear gives a fault response and is not cached, so the same address fetches again next time.
- R8: A request whose page is cached responds one cycle after acceptance, and no directory read is issued.
- R9: The cache holds 8 entries, replaced round-robin. After 9 distinct pages are installed into an empty cache, the first page misses and the second still hits.
- R10: A write to offset 0x310 carries an aligned base ORed with log2 of the range size in bits [5:0]. Every cached page inside that range is invalidated and pages outside it stay. A log2 of 48 or more purges everything.
- R11: If a purge covers the page being fetched while the fetch is in flight, the response is still delivered but the entry is not cached.
- R12: `dir_req_valid` stays high with a stable address until `dir_req_ready` is seen. The response is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_ofs | input | 12 | Register byte offset |
| cfg_wr_data | input | 64 | Register write data |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Block can accept a request |
| req_va | input | 48 | Virtual address |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_fault | output | 1 | Translation failed |
| rsp_pa | output | 48 | Physical address (0 on fault) |
| dir_req_valid | output | 1 | Directory read request |
| dir_req_ready | input | 1 | Memory accepts the read |
| dir_req_addr | output | 48 | Byte address of the directory entry |
| dir_rsp_valid | input | 1 | Directory read data valid |
| dir_rsp_data | input | 64 | Directory entry |

## Verification
The hardest case to reach is a purge that arrives while a directory read is still outstanding. The bench gets there by holding `dir_req_ready` low so the request stalls. While the request is stuck, the bench issues a purge covering that page, then releases the handshake. A second request to the same address must then produce a fresh directory read. Round-robin eviction is reached by filling the cache with nine distinct pages after a full purge.

// File: rtl/iovt_pkg.sv
package iovt_pkg;
    localparam int ADDR_W    = 48;
    localparam int ENTRY_W   = 64;
    localparam int VALID_BIT = 63;
    localparam int LOG2_W    = 6;
    localparam int OFS_W     = 12;

    localparam logic [OFS_W-1:0] OFS_WIN_BASE = 12'h300;
    localparam logic [OFS_W-1:0] OFS_WIN_MASK = 12'h308;
    localparam logic [OFS_W-1:0] OFS_PURGE    = 12'h310;
    localparam logic [OFS_W-1:0] OFS_PG_CFG   = 12'h318;
    localparam logic [OFS_W-1:0] OFS_DIR_BASE = 12'h320;

    typedef logic [ADDR_W-1:0] addr_t;

    typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT} walk_state_e;

    typedef struct packed {
        logic  fault;
        addr_t pa;
    } xlate_rsp_t;

    typedef struct packed {
        logic  fire;
        addr_t base;
        addr_t span;   // address bits ignored when matching
    } purge_t;

    function automatic logic [4:0] shift_of(input logic [1:0] code);
        case (code)
            2'd0:    return 5'd12;
            2'd1:    return 5'd13;
            2'd2:    return 5'd14;
            default: return 5'd16;
        endcase
    endfunction

    function automatic addr_t low_mask(input logic [LOG2_W-1:0] n);
        if (int'(n) >= ADDR_W) return '1;
        return ~({ADDR_W{1'b1}} << n);
    endfunction

    function automatic logic in_span(input addr_t a, input purge_t p);
        return p.fire && ((a & ~p.span) == (p.base & ~p.span));
    endfunction
endpackage

// File: rtl/iovt_regs.sv
module iovt_regs
    import iovt_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [OFS_W-1:0]    wr_ofs,
    input  logic [ENTRY_W-1:0]  wr_data,
    output logic                xl_on,
    output addr_t               win_base,
    output addr_t               win_mask,
    output addr_t               dir_base,
    output logic [4:0]          pg_shift,
    output logic                pg_ok,
    output purge_t              purge
);
    logic [1:0] pg_code;
    addr_t      span_w;

    always_ff @(posedge clk) begin
        if (rst) begin
            xl_on    <= 1'b0;
            win_base <= '0;
            win_mask <= '0;
            dir_base <= '0;
            pg_code  <= 2'd0;
            pg_ok    <= 1'b1;
        end else if (wr_en) begin
            case (wr_ofs)
                OFS_WIN_BASE: begin
                    xl_on    <= wr_data[0];
                    win_base <= {wr_data[ADDR_W-1:1], 1'b0};
                end
                OFS_WIN_MASK: win_mask <= wr_data[ADDR_W-1:0];
                OFS_PG_CFG: begin
                    pg_code <= wr_data[1:0];
                    pg_ok   <= (wr_data[ENTRY_W-1:2] == '0);
                end
                OFS_DIR_BASE: dir_base <= wr_data[ADDR_W-1:0];
                default: ;
            endcase
        end
    end

    assign pg_shift = shift_of(pg_code);
    assign span_w   = low_mask(wr_data[LOG2_W-1:0]);

    always_comb begin
        purge.fire = wr_en && (wr_ofs == OFS_PURGE);
        purge.span = span_w;
        purge.base = wr_data[ADDR_W-1:0] & ~span_w;
    end

    assert_base_zero_off_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_ofs == OFS_WIN_BASE && wr_data == '0) |=> !xl_on);

    assert_bad_code_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_ofs == OFS_PG_CFG && wr_data[ENTRY_W-1:2] != '0) |=> !pg_ok);
endmodule

// File: rtl/iovt_tlb.sv
module iovt_tlb
    import iovt_pkg::*;
#(
    parameter int ENTRIES = 8
) (
    input  logic   clk,
    input  logic   rst,
    input  addr_t  look_va,
    input  addr_t  off_mask,
    output logic   hit,
    output addr_t  hit_page,
    input  logic   ins_en,
    input  addr_t  ins_tag,
    input  addr_t  ins_page,
    input  purge_t purge
);
    localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic               vld_q  [ENTRIES];
    addr_t              tag_q  [ENTRIES];
    addr_t              page_q [ENTRIES];
    logic [ENTRIES-1:0] match;
    logic [PTR_W-1:0]   ptr;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                vld_q[g] <= 1'b0;
            end else if (ins_en && ptr == PTR_W'(g)) begin
                vld_q[g] <= 1'b1;
            end else if (in_span(tag_q[g], purge)) begin
                vld_q[g] <= 1'b0;
            end
            if (ins_en && ptr == PTR_W'(g)) begin
                tag_q[g]  <= ins_tag;
                page_q[g] <= ins_page;
            end
        end
        assign match[g] = vld_q[g] && (tag_q[g] == (look_va & ~off_mask));
    end

    always_ff @(posedge clk) begin
        if (rst)
            ptr <= '0;
        else if (ins_en)
            ptr <= (ptr == PTR_W'(ENTRIES - 1)) ? '0 : ptr + 1'b1;
    end

    always_comb begin
        hit_page = '0;
        for (int i = 0; i < ENTRIES; i++)
            if (match[i]) hit_page = hit_page | page_q[i];
    end
    assign hit = |match;

    assert_single_hit_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(match));
endmodule

// File: rtl/iova_translator.sv
module iova_translator
    import iovt_pkg::*;
#(
    parameter int ENTRIES = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_wr_en,
    input  logic [OFS_W-1:0]    cfg_wr_ofs,
    input  logic [ENTRY_W-1:0]  cfg_wr_data,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [ADDR_W-1:0]   req_va,
    output logic                rsp_valid,
    output logic                rsp_fault,
    output logic [ADDR_W-1:0]   rsp_pa,
    output logic                dir_req_valid,
    input  logic                dir_req_ready,
    output logic [ADDR_W-1:0]   dir_req_addr,
    input  logic                dir_rsp_valid,
    input  logic [ENTRY_W-1:0]  dir_rsp_data
);
    logic        xl_on, pg_ok;
    addr_t       win_base, win_mask, dir_base, off_mask;
    logic [4:0]  pg_shift;
    purge_t      purge;

    iovt_regs u_regs (
        .clk(clk), .rst(rst), .wr_en(cfg_wr_en), .wr_ofs(cfg_wr_ofs),
        .wr_data(cfg_wr_data), .xl_on(xl_on), .win_base(win_base),
        .win_mask(win_mask), .dir_base(dir_base), .pg_shift(pg_shift),
        .pg_ok(pg_ok), .purge(purge)
    );

    walk_state_e state;
    addr_t       va_q, addr_q, rel, entry_addr, ins_tag, ins_page, hit_page;
    xlate_rsp_t  rsp_q;
    logic        valid_q, kill_q, kill_now, hit, accept, in_win, ins_en, entry_ok;
    logic        unused_rsvd;

    assign off_mask   = low_mask({1'b0, pg_shift});
    assign accept     = req_valid && (state == ST_IDLE);
    assign in_win     = xl_on && pg_ok && ((req_va & win_mask) == (win_base & win_mask));
    assign rel        = req_va - win_base;
    assign entry_addr = dir_base + ((rel >> pg_shift) << 3);
    assign entry_ok   = dir_rsp_data[VALID_BIT];
    assign kill_now   = kill_q || in_span(va_q, purge);
    assign ins_tag    = va_q & ~off_mask;
    assign ins_page   = dir_rsp_data[ADDR_W-1:0] & ~off_mask;
    assign ins_en     = (state == ST_WAIT) && dir_rsp_valid && entry_ok && !kill_now;
    assign unused_rsvd = ^dir_rsp_data[VALID_BIT-1:ADDR_W];

    iovt_tlb #(.ENTRIES(ENTRIES)) u_tlb (
        .clk(clk), .rst(rst), .look_va(req_va), .off_mask(off_mask),
        .hit(hit), .hit_page(hit_page), .ins_en(ins_en), .ins_tag(ins_tag),
        .ins_page(ins_page), .purge(purge)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            va_q    <= '0;
            addr_q  <= '0;
            kill_q  <= 1'b0;
            valid_q <= 1'b0;
            rsp_q   <= '0;
        end else begin
            valid_q <= 1'b0;
            case (state)
                ST_IDLE: if (accept) begin
                    va_q   <= req_va;
                    kill_q <= 1'b0;
                    if (!in_win) begin
                        valid_q <= 1'b1;
                        rsp_q   <= '{fault: 1'b1, pa: '0};
                    end else if (hit) begin
                        valid_q <= 1'b1;
                        rsp_q   <= '{fault: 1'b0, pa: hit_page | (req_va & off_mask)};
                    end else begin
                        addr_q <= entry_addr;
                        state  <= ST_ISSUE;
                    end
                end
                ST_ISSUE: begin
                    kill_q <= kill_now;
                    if (dir_req_ready) state <= ST_WAIT;
                end
                ST_WAIT: begin
                    kill_q <= kill_now;
                    if (dir_rsp_valid) begin
                        valid_q <= 1'b1;
                        rsp_q   <= entry_ok ? '{fault: 1'b0, pa: ins_page | (va_q & off_mask)}
                                            : '{fault: 1'b1, pa: '0};
                        state   <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign req_ready     = (state == ST_IDLE);
    assign dir_req_valid = (state == ST_ISSUE);
    assign dir_req_addr  = addr_q;
    assign rsp_valid     = valid_q;
    assign rsp_fault     = rsp_q.fault;
    assign rsp_pa        = rsp_q.pa;

    assert_req_hold_R12: assert property (@(posedge clk) disable iff (rst)
        (dir_req_valid && !dir_req_ready) |=> (dir_req_valid && $stable(dir_req_addr)));

    assert_fault_pa_zero_R3: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_fault) |-> (rsp_pa == '0));

    assert_offset_kept_R5: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_fault) |-> (((rsp_pa ^ va_q) & off_mask) == '0));
endmodule

// File: tb/sim_iova_translator.sv
module sim_iova_translator;
    localparam logic [47:0] BASE = 48'h0000_4000_0000;
    localparam logic [47:0] DIR  = 48'h0001_0000_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr_en = 1'b0;
    logic [11:0] cfg_wr_ofs = '0;
    logic [63:0] cfg_wr_data = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [47:0] req_va = '0;
    logic        rsp_valid, rsp_fault;
    logic [47:0] rsp_pa;
    logic        dir_req_valid;
    logic        dir_req_ready = 1'b1;
    logic [47:0] dir_req_addr;
    logic        dir_rsp_valid = 1'b0;
    logic [63:0] dir_rsp_data = '0;

    int checks = 0;
    int errors = 0;
    int reads = 0;
    logic [47:0] last_addr = '0;
    logic [47:0] bad_addr = '1;
    logic        pend = 1'b0;
    int          pcnt = 0;
    logic [47:0] paddr = '0;
    bit          done = 0;

    always #4 clk = ~clk;

    iova_translator u0 (
        .clk(clk), .rst(rst), .cfg_wr_en(cfg_wr_en), .cfg_wr_ofs(cfg_wr_ofs),
        .cfg_wr_data(cfg_wr_data), .req_valid(req_valid), .req_ready(req_ready),
        .req_va(req_va), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
        .rsp_pa(rsp_pa), .dir_req_valid(dir_req_valid), .dir_req_ready(dir_req_ready),
        .dir_req_addr(dir_req_addr), .dir_rsp_valid(dir_rsp_valid),
        .dir_rsp_data(dir_rsp_data)
    );

    function automatic logic [63:0] entry_of(input logic [47:0] a);
        if (a == bad_addr) return 64'h0000_0000_0ABC_D000;
        return {1'b1, 15'h0, 48'h0080_0000_0000 | (a << 6)};
    endfunction

    function automatic logic [47:0] dir_of(input logic [47:0] va, input int sh);
        return DIR + (((va - BASE) >> sh) << 3);
    endfunction

    function automatic logic [47:0] pa_of(input logic [47:0] va, input int sh);
        logic [47:0] m;
        logic [63:0] e;
        m = (48'd1 << sh) - 48'd1;
        e = entry_of(dir_of(va, sh));
        return (e[47:0] & ~m) | (va & m);
    endfunction

    always @(posedge clk) begin
        dir_rsp_valid <= 1'b0;
        if (dir_req_valid && dir_req_ready) begin
            pend      <= 1'b1;
            pcnt      <= 2;
            paddr     <= dir_req_addr;
            last_addr <= dir_req_addr;
            reads     <= reads + 1;
        end else if (pend) begin
            if (pcnt == 0) begin
                dir_rsp_valid <= 1'b1;
                dir_rsp_data  <= entry_of(paddr);
                pend          <= 1'b0;
            end else begin
                pcnt <= pcnt - 1;
            end
        end
    end

    task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] ofs, input logic [63:0] d);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_wr_ofs = ofs; cfg_wr_data = d;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    task automatic xlate(input logic [47:0] va, output logic flt, output logic [47:0] pa, output int lat);
        @(negedge clk);
        req_va = va; req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        while (!rsp_valid && lat < 100) begin
            @(negedge clk);
            lat++;
        end
        flt = rsp_fault; pa = rsp_pa;
        @(negedge clk);
        chk(!rsp_valid, "R12 pulse", {63'd0, rsp_valid}, 64'd0);
    endtask

    task automatic purge_all();
        wr(12'h310, 64'd48);
    endtask

    task automatic t_reset();
        logic f; logic [47:0] p; int l; int r0;
        chk(req_ready == 1'b1, "R1 ready", {63'd0, req_ready}, 64'd1);
        chk(rsp_valid == 1'b0, "R1 rsp", {63'd0, rsp_valid}, 64'd0);
        chk(dir_req_valid == 1'b0, "R1 dirreq", {63'd0, dir_req_valid}, 64'd0);
        r0 = reads;
        xlate(BASE + 48'h1000, f, p, l);
        chk(f == 1'b1, "R1 disabled fault", {63'd0, f}, 64'd1);
        chk(reads == r0, "R1 no read", 64'(reads), 64'(r0));
    endtask

    task automatic t_setup();
        wr(12'h308, 64'hFFFF_FFFF_C000_0000);
        wr(12'h320, {16'h0, DIR});
        wr(12'h318, 64'd0);
        wr(12'h300, {16'h0, BASE} | 64'd1);
    endtask

    task automatic t_miss_hit();
        logic f; logic [47:0] p; int l; int r0;
        logic [47:0] va = BASE + 48'h3ABC;
        r0 = reads;
        xlate(va, f, p, l);
        chk(f == 1'b0, "R4 miss no fault", {63'd0, f}, 64'd0);
        chk(last_addr == dir_of(va, 12), "R4 dir addr", {16'h0, last_addr}, {16'h0, dir_of(va, 12)});
        chk(p == pa_of(va, 12), "R5 pa shift12", {16'h0, p}, {16'h0, pa_of(va, 12)});
        chk(reads == r0 + 1, "R4 one read", 64'(reads), 64'(r0 + 1));
        xlate(va + 48'h10, f, p, l);
        chk(l == 1, "R8 hit latency", 64'(l), 64'd1);
        chk(reads == r0 + 1, "R8 no read on hit", 64'(reads), 64'(r0 + 1));
        chk(p == pa_of(va + 48'h10, 12), "R8 hit pa", {16'h0, p}, {16'h0, pa_of(va + 48'h10, 12)});
    endtask

    task automatic t_outside();
        logic f; logic [47:0] p; int l; int r0;
        r0 = reads;
        xlate(48'h0000_8000_0000, f, p, l);
        chk(f == 1'b1, "R3 above window", {63'd0, f}, 64'd1);
        chk(p == '0, "R3 fault pa zero", {16'h0, p}, 64'd0);
        xlate(48'h0000_3FFF_FFF8, f, p, l);
        chk(f == 1'b1, "R3 below window", {63'd0, f}, 64'd1);
        chk(reads == r0, "R3 no read", 64'(reads), 64'(r0));
    endtask

    task automatic t_bad_entry();
        logic f; logic [47:0] p; int l; int r0;
        logic [47:0] va = BASE + 48'h5000;
        bad_addr = dir_of(va, 12);
        r0 = reads;
        xlate(va, f, p, l);
        chk(f == 1'b1, "R7 invalid entry fault", {63'd0, f}, 64'd1);
        xlate(va, f, p, l);
        chk(reads == r0 + 2, "R7 not cached", 64'(reads), 64'(r0 + 2));
        bad_addr = '1;
    endtask

    task automatic t_pgsize();
        logic f; logic [47:0] p; int l;
        int sh;
        logic [47:0] va = BASE + 48'h12345;
        for (int c = 1; c < 4; c++) begin
            sh = (c == 3) ? 16 : 12 + c;
            purge_all();
            wr(12'h318, 64'(c));
            xlate(va, f, p, l);
            chk(last_addr == dir_of(va, sh), "R5 dir addr per code", {16'h0, last_addr}, {16'h0, dir_of(va, sh)});
            chk(p == pa_of(va, sh), "R5 pa per code", {16'h0, p}, {16'h0, pa_of(va, sh)});
        end
        wr(12'h318, 64'd0);
        purge_all();
    endtask

    task automatic t_bad_code();
        logic f; logic [47:0] p; int l;
        wr(12'h318, 64'd4);
        xlate(BASE + 48'h3000, f, p, l);
        chk(f == 1'b1, "R6 invalid code fault", {63'd0, f}, 64'd1);
        wr(12'h318, 64'd0);
        xlate(BASE + 48'h3000, f, p, l);
        chk(f == 1'b0, "R6 valid code restored", {63'd0, f}, 64'd0);
    endtask

    task automatic t_disable();
        logic f; logic [47:0] p; int l;
        wr(12'h300, 64'd0);
        xlate(BASE + 48'h3000, f, p, l);
        chk(f == 1'b1, "R2 zero base disables", {63'd0, f}, 64'd1);
        wr(12'h300, {16'h0, BASE} | 64'd1);
    endtask

    task automatic t_round_robin();
        logic f; logic [47:0] p; int l; int r0;
        purge_all();
        r0 = reads;
        for (int i = 0; i < 9; i++) xlate(BASE + 48'(i) * 48'h1000, f, p, l);
        chk(reads == r0 + 9, "R9 nine fills", 64'(reads), 64'(r0 + 9));
        xlate(BASE + 48'h1000, f, p, l);
        chk(reads == r0 + 9 && l == 1, "R9 second page kept", 64'(reads), 64'(r0 + 9));
        xlate(BASE, f, p, l);
        chk(reads == r0 + 10, "R9 first page evicted", 64'(reads), 64'(r0 + 10));
    endtask

    task automatic t_purge_range();
        logic f; logic [47:0] p; int l; int r0;
        logic [47:0] a = BASE + 48'h1000;
        logic [47:0] b = 48'h0000_6000_2000;
        purge_all();
        xlate(a, f, p, l);
        xlate(b, f, p, l);
        wr(12'h310, 64'h0000_0000_6000_0000 | 64'd29);
        r0 = reads;
        xlate(a, f, p, l);
        chk(reads == r0 && l == 1, "R10 outside range kept", 64'(reads), 64'(r0));
        xlate(b, f, p, l);
        chk(reads == r0 + 1, "R10 inside range purged", 64'(reads), 64'(r0 + 1));
        chk(p == pa_of(b, 12), "R10 refetch pa", {16'h0, p}, {16'h0, pa_of(b, 12)});
    endtask

    task automatic t_purge_inflight();
        logic f; logic [47:0] p; int l; int r0;
        logic [47:0] c = BASE + 48'h7000;
        purge_all();
        dir_req_ready = 1'b0;
        r0 = reads;
        fork
            xlate(c, f, p, l);
            begin
                repeat (3) @(negedge clk);
                chk(dir_req_valid == 1'b1, "R12 req held", {63'd0, dir_req_valid}, 64'd1);
                chk(dir_req_addr == dir_of(c, 12), "R12 addr stable", {16'h0, dir_req_addr}, {16'h0, dir_of(c, 12)});
                wr(12'h310, {16'h0, c & ~48'hFFF} | 64'd12);
                dir_req_ready = 1'b1;
            end
        join
        chk(f == 1'b0 && p == pa_of(c, 12), "R11 response delivered", {16'h0, p}, {16'h0, pa_of(c, 12)});
        xlate(c, f, p, l);
        chk(reads == r0 + 2, "R11 killed fill not cached", 64'(reads), 64'(r0 + 2));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_setup();
        t_miss_hit();
        t_outside();
        t_bad_entry();
        t_pgsize();
        t_bad_code();
        t_disable();
        t_round_robin();
        t_purge_range();
        t_purge_inflight();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule